// File: doc/BRIEF.md
# Queue Status and Interrupt Source Controller

This block watches a bank of hardware queues and turns their fill levels into condition flags and interrupts. For every queue it receives the current occupancy, the buffer size and two thresholds. From these it derives four flags: empty, nearly empty, nearly full and full. The flags are packed into status words that a processor reads over a simple word-addressed register bus.

The queues form two groups. In the lower group (queues 0 to NUM_LO-1), each queue has a 4-bit source field that picks one of eight conditions as its interrupt source. The eight conditions are the four flags and the inverse of each. In the upper group (the next NUM_UP queues), the interrupt source is always nearly empty. When a queue's selected condition becomes true and its enable bit is set, a sticky pending bit is latched. Each group has one interrupt line, which is the OR of that group's pending bits. Software acknowledges by writing back the value it read from the pending register, and each 1 clears the matching bit.

Top module: `qstat_irq_ctrl`

## Requirements
- R1: Lower-group status is read at word addresses 0..3. Queue q sits in word q/8 at bits 4*(q%8)+3..4*(q%8), with bit 0 = empty (occupancy 0), bit 1 = nearly empty, bit 2 = nearly full and bit 3 = full.
- R2: Nearly empty is 1 when occupancy <= the NE threshold. Nearly full is 1 when the free space (size minus occupancy, floored at 0) <= the NF threshold. Full is 1 when occupancy >= size.
- R3: Upper-group queue u (queue number NUM_LO+u) reports nearly empty at bit u of word 4 and full at bit u of word 5.
- R4: The source fields are read and written at words 8..11, 4 bits per queue, laid out like R1. Bits 2..0 select the condition: 0 empty, 1 nearly empty, 2 nearly full, 3 full, and 4..7 the inverse of 0..3 respectively.
- R5: Bit 3 of every source field, queue 0 included, is stored and read back exactly as written, and it has no effect on which condition is selected.
- R6: The enable registers are at word 12 (lower) and word 13 (upper). The bit index is the queue number modulo 32.
- R7: A pending bit is set at the clock edge where its condition is 1 and was 0 at the previous edge, provided its enable bit is 1. A rising edge while the queue is disabled is lost, and enabling a queue later does not set the bit.
- R8: The interrupt source of an upper-group queue is always its nearly-empty flag.
- R9: The pending registers are at word 14 (lower) and word 15 (upper). Writing a 1 clears that bit and writing a 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R10: irq_lo is the OR of the lower pending bits, and irq_up is the OR of the upper pending bits.
- R11: While rst_n is low at a clock edge, all source, enable and pending registers return to 0, and both interrupt lines go low.
- R12: Words 6, 7 and any other unmapped address read 0. Writes to the status words (0..5) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_occ | input | (NUM_LO+NUM_UP)*CNT_W | Occupancy of every queue, queue q at bits q*CNT_W upward |
| q_size | input | (NUM_LO+NUM_UP)*CNT_W | Buffer size in entries per queue |
| q_ne_lvl | input | (NUM_LO+NUM_UP)*CNT_W | Nearly-empty threshold per queue |
| q_nf_lvl | input | (NUM_LO+NUM_UP)*CNT_W | Nearly-full threshold (free entries) per queue |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_lo | output | 1 | Lower-group interrupt |
| irq_up | output | 1 | Upper-group interrupt |

## Verification
The hardest case to reach is a pending bit being set by a condition edge in the same cycle that software writes a clear to that bit. To reach it, the stimulus holds a queue at the opposite level for one cycle, then changes its occupancy in the same cycle as the write-back strobe. The inverse selections also need care, because their condition is already true when a queue is idle: the stimulus first drives the queue to full so that "not full" falls, and only then lets it drain. Beyond these directed cases, a long random phase drives occupancies and register writes, and a behavioural model is compared against both the interrupt lines and the read data on every clock.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  localparam int REG_W      = 32;
  localparam int FLD_W      = 4;
  localparam int Q_PER_WORD = REG_W / FLD_W;
  localparam int MAX_GRP    = 32;
  localparam int N_WORDS    = MAX_GRP / Q_PER_WORD;
  localparam int ADDR_W     = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  // word map
  localparam reg_addr_t A_LSTAT0  = 4'd0;
  localparam reg_addr_t A_UNE     = 4'd4;
  localparam reg_addr_t A_UFULL   = 4'd5;
  localparam reg_addr_t A_SEL0    = 4'd8;
  localparam reg_addr_t A_EN_LO   = 4'd12;
  localparam reg_addr_t A_EN_UP   = 4'd13;
  localparam reg_addr_t A_PEND_LO = 4'd14;
  localparam reg_addr_t A_PEND_UP = 4'd15;

  // nibble layout: bit3 full, bit2 nearly full, bit1 nearly empty, bit0 empty
  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qflags_t;

  typedef enum logic [2:0] {
    SRC_EMPTY   = 3'd0,
    SRC_NEMPTY  = 3'd1,
    SRC_NFULL   = 3'd2,
    SRC_FULL    = 3'd3,
    SRC_NOT_E   = 3'd4,
    SRC_NOT_NE  = 3'd5,
    SRC_NOT_NF  = 3'd6,
    SRC_NOT_F   = 3'd7
  } src_sel_e;

  function automatic logic pick_cond(input logic [2:0] code, input qflags_t f);
    logic res;
    case (src_sel_e'(code))
      SRC_EMPTY:  res = f.empty;
      SRC_NEMPTY: res = f.nempty;
      SRC_NFULL:  res = f.nfull;
      SRC_FULL:   res = f.full;
      SRC_NOT_E:  res = ~f.empty;
      SRC_NOT_NE: res = ~f.nempty;
      SRC_NOT_NF: res = ~f.nfull;
      default:    res = ~f.full;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/qsc_flag_unit.sv
module qsc_flag_unit
  import qsc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] occ,
  input  logic [CNT_W-1:0] size,
  input  logic [CNT_W-1:0] ne_lvl,
  input  logic [CNT_W-1:0] nf_lvl,
  output qflags_t          flags
);

  function automatic logic [CNT_W-1:0] free_space(input logic [CNT_W-1:0] o,
                                                   input logic [CNT_W-1:0] s);
    return (o >= s) ? '0 : (s - o);
  endfunction

  always_comb begin
    flags.empty  = (occ == '0);
    flags.nempty = (occ <= ne_lvl);
    flags.nfull  = (free_space(occ, size) <= nf_lvl);
    flags.full   = (occ >= size);
  end

endmodule

// File: rtl/qsc_irq_group.sv
module qsc_irq_group #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] set_ev,
  output logic         irq
);

  logic [N-1:0] cond_q;

  // rising edge of the selected condition, gated by enable
  assign set_ev = cond & ~cond_q & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      pend   <= '0;
    end else begin
      cond_q <= cond;
      pend   <= (pend & ~clr) | set_ev;
    end
  end

  assign irq = |pend;

endmodule

// File: rtl/qstat_irq_ctrl.sv
module qstat_irq_ctrl
  import qsc_pkg::*;
#(
  parameter int NUM_LO = 32,
  parameter int NUM_UP = 32,
  parameter int CNT_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [(NUM_LO+NUM_UP)*CNT_W-1:0]   q_occ,
  input  logic [(NUM_LO+NUM_UP)*CNT_W-1:0]   q_size,
  input  logic [(NUM_LO+NUM_UP)*CNT_W-1:0]   q_ne_lvl,
  input  logic [(NUM_LO+NUM_UP)*CNT_W-1:0]   q_nf_lvl,
  input  logic [3:0]                         reg_addr,
  input  logic                               reg_wr,
  input  logic [31:0]                        reg_wdata,
  output logic [31:0]                        reg_rdata,
  output logic                               irq_lo,
  output logic                               irq_up
);

  localparam int NUM_Q = NUM_LO + NUM_UP;
  localparam int SEL_W = NUM_LO * FLD_W;
  localparam int PAD_W = MAX_GRP * FLD_W;

  qflags_t            flags [NUM_Q];
  logic [SEL_W-1:0]   sel_q;
  logic [NUM_LO-1:0]  en_lo_q, cond_lo, clr_lo, pend_lo, set_lo;
  logic [NUM_UP-1:0]  en_up_q, cond_up, clr_up, pend_up, set_up;
  logic [PAD_W-1:0]   lstat_pad, sel_pad;
  logic [REG_W-1:0]   une_w, uf_w;

  // per-queue flag derivation
  for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_flag
    qsc_flag_unit #(.CNT_W(CNT_W)) u_flag (
      .occ    (q_occ   [gq*CNT_W +: CNT_W]),
      .size   (q_size  [gq*CNT_W +: CNT_W]),
      .ne_lvl (q_ne_lvl[gq*CNT_W +: CNT_W]),
      .nf_lvl (q_nf_lvl[gq*CNT_W +: CNT_W]),
      .flags  (flags[gq])
    );
  end

  // interrupt source selection
  for (genvar gl = 0; gl < NUM_LO; gl++) begin : g_lsrc
    assign cond_lo[gl] = pick_cond(sel_q[gl*FLD_W +: 3], flags[gl]);
  end
  for (genvar gu = 0; gu < NUM_UP; gu++) begin : g_usrc
    assign cond_up[gu] = flags[NUM_LO+gu].nempty;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_lo_q <= '0;
      en_up_q <= '0;
    end else if (reg_wr) begin
      for (int q = 0; q < NUM_LO; q++) begin
        if (reg_addr == A_SEL0 + reg_addr_t'(q / Q_PER_WORD))
          sel_q[q*FLD_W +: FLD_W] <= reg_wdata[(q % Q_PER_WORD)*FLD_W +: FLD_W];
      end
      if (reg_addr == A_EN_LO) en_lo_q <= reg_wdata[NUM_LO-1:0];
      if (reg_addr == A_EN_UP) en_up_q <= reg_wdata[NUM_UP-1:0];
    end
  end

  // write-one-to-clear masks
  assign clr_lo = (reg_wr && reg_addr == A_PEND_LO) ? reg_wdata[NUM_LO-1:0] : '0;
  assign clr_up = (reg_wr && reg_addr == A_PEND_UP) ? reg_wdata[NUM_UP-1:0] : '0;

  qsc_irq_group #(.N(NUM_LO)) u_grp_lo (
    .clk(clk), .rst_n(rst_n), .cond(cond_lo), .en(en_lo_q), .clr(clr_lo),
    .pend(pend_lo), .set_ev(set_lo), .irq(irq_lo)
  );

  qsc_irq_group #(.N(NUM_UP)) u_grp_up (
    .clk(clk), .rst_n(rst_n), .cond(cond_up), .en(en_up_q), .clr(clr_up),
    .pend(pend_up), .set_ev(set_up), .irq(irq_up)
  );

  // packed read images
  always_comb begin
    lstat_pad = '0;
    sel_pad   = '0;
    une_w     = '0;
    uf_w      = '0;
    for (int q = 0; q < NUM_LO; q++) begin
      lstat_pad[q*FLD_W +: FLD_W] = flags[q];
      sel_pad[q*FLD_W +: FLD_W]   = sel_q[q*FLD_W +: FLD_W];
    end
    for (int u = 0; u < NUM_UP; u++) begin
      une_w[u] = flags[NUM_LO+u].nempty;
      uf_w[u]  = flags[NUM_LO+u].full;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_UNE:     reg_rdata = une_w;
      A_UFULL:   reg_rdata = uf_w;
      A_EN_LO:   reg_rdata = REG_W'(en_lo_q);
      A_EN_UP:   reg_rdata = REG_W'(en_up_q);
      A_PEND_LO: reg_rdata = REG_W'(pend_lo);
      A_PEND_UP: reg_rdata = REG_W'(pend_up);
      default: begin
        for (int k = 0; k < N_WORDS; k++) begin
          if (reg_addr == A_LSTAT0 + reg_addr_t'(k))
            reg_rdata = lstat_pad[k*REG_W +: REG_W];
          if (reg_addr == A_SEL0 + reg_addr_t'(k))
            reg_rdata = sel_pad[k*REG_W +: REG_W];
        end
      end
    endcase
  end

endmodule

// File: rtl/qstat_irq_ctrl_chk.sv
module qstat_irq_ctrl_chk
  import qsc_pkg::*;
#(
  parameter int NUM_LO = 32,
  parameter int NUM_UP = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [3:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     irq_lo,
  input logic                     irq_up,
  input logic [NUM_LO-1:0]        pend_lo,
  input logic [NUM_UP-1:0]        pend_up,
  input logic [NUM_LO-1:0]        en_lo_q,
  input logic [NUM_UP-1:0]        en_up_q,
  input logic [NUM_LO-1:0]        set_lo,
  input logic [NUM_UP-1:0]        set_up,
  input logic [NUM_LO*FLD_W-1:0]  sel_q
);

  AST_IRQ_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> $past(|set_lo)); // R7

  AST_FULL_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PEND_LO && ((pend_lo & ~reg_wdata[NUM_LO-1:0]) == '0) && set_lo == '0)
      |=> !irq_lo); // R10

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (en_lo_q == '0 && en_up_q == '0 && sel_q == '0 && !irq_lo && !irq_up)); // R11

  AST_PEND_UP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == A_PEND_UP) && set_up == '0) |=> $stable(pend_up)); // R9

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(sel_q)); // R4

  AST_EN_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_EN_LO) |=> $stable(en_lo_q)); // R6

endmodule

bind qstat_irq_ctrl qstat_irq_ctrl_chk #(.NUM_LO(NUM_LO), .NUM_UP(NUM_UP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_lo(irq_lo), .irq_up(irq_up), .pend_lo(pend_lo), .pend_up(pend_up),
  .en_lo_q(en_lo_q), .en_up_q(en_up_q), .set_lo(set_lo), .set_up(set_up), .sel_q(sel_q)
);

// File: tb/qstat_irq_ctrl_bench.sv
module qstat_irq_ctrl_bench;

  localparam int NQ = 64;
  localparam int CW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [NQ*CW-1:0] q_occ, q_size, q_ne_lvl, q_nf_lvl;
  logic [3:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_up;

  logic [7:0] occ [NQ];
  logic [7:0] sz  [NQ];
  logic [7:0] ne  [NQ];
  logic [7:0] nf  [NQ];

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // model state
  int       m_sel [32];
  bit       m_prev [NQ];
  bit [31:0] m_en_lo, m_en_up, m_int_lo, m_int_up;
  bit [31:0] nlo, nup;
  bit        cnow;
  int        wa;

  always #2 clk = ~clk;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_occ[q*CW +: CW]    = occ[q];
      q_size[q*CW +: CW]   = sz[q];
      q_ne_lvl[q*CW +: CW] = ne[q];
      q_nf_lvl[q*CW +: CW] = nf[q];
    end
  end

  qstat_irq_ctrl u_qstat_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .q_occ(q_occ), .q_size(q_size),
    .q_ne_lvl(q_ne_lvl), .q_nf_lvl(q_nf_lvl), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lo(irq_lo), .irq_up(irq_up)
  );

  // k: 0 empty, 1 nearly empty, 2 nearly full, 3 full
  function automatic bit m_flag(int q, int k);
    int o = occ[q];
    int s = sz[q];
    int t_ne = ne[q];
    int t_nf = nf[q];
    case (k)
      0:       return o == 0;
      1:       return !(o > t_ne);
      2:       return (o + t_nf) >= s;
      default: return !(o < s);
    endcase
  endfunction

  function automatic bit m_cond(int q);
    int code;
    if (q >= 32) return m_flag(q, 1);
    code = m_sel[q] & 7;
    return m_flag(q, code & 3) ^ (code >= 4);
  endfunction

  function automatic bit [31:0] m_read(int a);
    bit [31:0] r = 0;
    if (a < 4) begin
      for (int i = 0; i < 8; i++)
        for (int k = 0; k < 4; k++) r[i*4+k] = m_flag(a*8+i, k);
    end else if (a == 4) begin
      for (int u = 0; u < 32; u++) r[u] = m_flag(32+u, 1);
    end else if (a == 5) begin
      for (int u = 0; u < 32; u++) r[u] = m_flag(32+u, 3);
    end else if (a >= 8 && a < 12) begin
      for (int i = 0; i < 8; i++) r[i*4 +: 4] = 4'(m_sel[(a-8)*8+i]);
    end else if (a == 12) r = m_en_lo;
    else if (a == 13) r = m_en_up;
    else if (a == 14) r = m_int_lo;
    else if (a == 15) r = m_int_up;
    return r;
  endfunction

  function automatic string tag_of(int a);
    if (a < 4) return "R1";
    if (a == 4 || a == 5) return "R3";
    if (a >= 8 && a < 12) return "R4";
    if (a == 12 || a == 13) return "R6";
    if (a >= 14) return "R9";
    return "R12";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) m_prev[q] = 0;
      for (int i = 0; i < 32; i++) m_sel[i] = 0;
      m_en_lo = 0; m_en_up = 0; m_int_lo = 0; m_int_up = 0;
    end else begin
      nlo = m_int_lo;
      nup = m_int_up;
      if (reg_wr && reg_addr == 14) nlo &= ~reg_wdata;
      if (reg_wr && reg_addr == 15) nup &= ~reg_wdata;
      for (int q = 0; q < NQ; q++) begin
        cnow = m_cond(q);
        if (cnow && !m_prev[q]) begin
          if (q < 32 && m_en_lo[q]) nlo[q] = 1'b1;
          if (q >= 32 && m_en_up[q-32]) nup[q-32] = 1'b1;
        end
        m_prev[q] = cnow;
      end
      if (reg_wr) begin
        wa = int'(reg_addr);
        if (wa >= 8 && wa < 12)
          for (int i = 0; i < 8; i++) m_sel[(wa-8)*8+i] = int'((reg_wdata >> (4*i)) & 32'hF);
        if (wa == 12) m_en_lo = reg_wdata;
        if (wa == 13) m_en_up = reg_wdata;
      end
      m_int_lo = nlo;
      m_int_up = nup;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(int'(reg_addr)), reg_rdata, m_read(int'(reg_addr)));
      chk("R10 irq_lo", 32'(irq_lo), 32'(m_int_lo != 0));
      chk("R10 irq_up", 32'(irq_up), 32'(m_int_up != 0));
    end
  end

  task automatic wr_reg(int a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd_reg(int a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_addr = 4'(a);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic set_occ(int q, int v);
    @(posedge clk); #1;
    occ[q] = 8'(v);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      occ[q] = 0; sz[q] = 16; ne[q] = 2; nf[q] = 2;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset state
    rd_reg(12, 0, "R11 en_lo");
    rd_reg(8, 0, "R11 sel");
    rd_reg(14, 0, "R11 pend_lo");
    rd_reg(15, 0, "R11 pend_up");
    chk("R11 irq", 32'({irq_lo, irq_up}), 0);

    // R1 / R3 idle queues
    rd_reg(0, 32'h33333333, "R1 idle");
    rd_reg(4, 32'hFFFFFFFF, "R3 idle ne");

    // R2 full queue flags
    set_occ(5, 16);
    set_occ(40, 16);
    rd_reg(0, 32'h33C33333, "R2 full nibble");
    rd_reg(5, 32'h00000100, "R3 full word");
    rd_reg(4, 32'hFFFFFEFF, "R3 ne word");

    // R4/R5 source fields, bit3 on queue 0 kept
    wr_reg(8, 32'h00000208);
    rd_reg(8, 32'h00000208, "R5 readback");
    wr_reg(12, 32'h4);
    set_occ(2, 15);
    rd_reg(14, 32'h4, "R7 nf edge");
    chk("R10 irq_lo high", 32'(irq_lo), 1);

    // R5 queue 0 still acts on empty; R9 partial clears
    wr_reg(12, 32'h5);
    set_occ(0, 3);
    set_occ(0, 0);
    rd_reg(14, 32'h5, "R5 bit3 no effect");
    wr_reg(14, 32'h1);
    rd_reg(14, 32'h4, "R9 clear one");
    wr_reg(14, 32'h4);
    rd_reg(14, 32'h0, "R9 clear rest");
    chk("R10 irq_lo low", 32'(irq_lo), 0);

    // R7 edge while disabled is lost
    set_occ(3, 3);
    set_occ(3, 0);
    rd_reg(14, 32'h0, "R7 disabled edge");
    wr_reg(12, 32'hD);
    rd_reg(14, 32'h0, "R7 late enable");

    // R4 inverse selection: queue 1 not-full
    wr_reg(8, 32'h00000278);
    wr_reg(12, 32'hF);
    set_occ(1, 16);
    rd_reg(14, 32'h0, "R4 not-full falls");
    set_occ(1, 10);
    rd_reg(14, 32'h2, "R4 not-full rises");

    // R8 upper group fixed to nearly empty
    wr_reg(13, 32'h100);
    set_occ(40, 1);
    rd_reg(15, 32'h100, "R8 upper ne");
    chk("R10 irq_up high", 32'(irq_up), 1);

    // R9 set wins over simultaneous clear
    wr_reg(14, 32'h2);
    set_occ(1, 16);
    @(posedge clk); #1;
    occ[1] = 10; reg_wr = 1; reg_addr = 14; reg_wdata = 32'h2;
    @(posedge clk); #1;
    reg_wr = 0;
    rd_reg(14, 32'h2, "R9 set wins");

    // R12 unmapped and status writes
    rd_reg(6, 0, "R12 unmapped");
    wr_reg(5, 32'hFFFFFFFF);
    rd_reg(5, 32'h0, "R12 status write ignored");

    // random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      for (int j = 0; j < 3; j++) occ[$urandom % NQ] = 8'($urandom % 20);
      if ($urandom % 32 == 0) ne[$urandom % NQ] = 8'($urandom % 8);
      if ($urandom % 32 == 0) nf[$urandom % NQ] = 8'($urandom % 8);
      reg_addr  = 4'($urandom % 16);
      reg_wr    = ($urandom % 4 == 0);
      reg_wdata = $urandom;
    end
    @(posedge clk); #1;
    reg_wr = 0;
    repeat (2) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule